// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Bank

This block holds operations waiting for a single floating-point adder in a dynamically scheduled datapath. It has a small bank of stations, three by default, each with a fixed producer tag (10, 11 and 12 by default). On issue, the lowest-numbered free station is taken. The station's tag comes back on `iss_tag`, so the surrounding rename logic can record it as the producer of the destination register. For each operand, the issuer gives either a value or the 4-bit tag of the producer that will supply it. A tag of zero means the value is already present.

Every busy station watches a shared result broadcast bus. When a waiting operand's tag matches the broadcast tag, the station copies the data. A station whose operands are both present, and which has not yet been sent, becomes eligible for the adder. One eligible station per cycle is sent, and the lowest index wins. The station stays occupied while the adder works. It is released when the adder's result, carrying the station's own tag, appears on the broadcast bus. Within a cycle, the broadcast is applied before issue.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `iss_tag` is 10 and `disp_valid` is 0.
- R2: An accepted issue takes the lowest-numbered free station, and `iss_tag` shows that station's tag (10 + index) in the cycle of the issue.
- R3: With every station occupied, `iss_ready` is 0 and an issue request is ignored: it is never dispatched, and the bank stays full.
- R4: An operand issued with tag 0 is stored with the value given on the issue port.
- R5: A waiting operand whose tag equals the tag of a valid broadcast captures the broadcast data, and from then on it counts as present.
- R6: When an issue and a broadcast happen in the same cycle, an issued operand waiting on the broadcast tag receives the broadcast data at once.
- R7: A station is dispatched only when both of its operands hold valid data.
- R8: A station is not dispatched in the cycle it is issued; the earliest dispatch is the following cycle.
- R9: When several stations are eligible, the one with the lowest index is dispatched, one per cycle.
- R10: Each station is dispatched once and stays occupied until a broadcast carries its own tag; only then does it become free.
- R11: A dispatch presents the station's operation (0 = add, 1 = subtract), both operand values and the station's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 1 | Operation: 0 add, 1 subtract |
| iss_a_tag | input | 4 | Producer tag of operand A, 0 if value given |
| iss_a_val | input | 32 | Value of operand A |
| iss_b_tag | input | 4 | Producer tag of operand B, 0 if value given |
| iss_b_val | input | 32 | Value of operand B |
| iss_ready | output | 1 | At least one station is free |
| iss_tag | output | 4 | Tag of the station an issue would take |
| res_valid | input | 1 | Broadcast bus carries a result |
| res_tag | input | 4 | Producer tag of the broadcast result |
| res_data | input | 32 | Broadcast result value |
| disp_valid | output | 1 | A station is sent to the adder this cycle |
| disp_op | output | 1 | Operation of the dispatched station |
| disp_a | output | 32 | Operand A of the dispatched station |
| disp_b | output | 32 | Operand B of the dispatched station |
| disp_tag | output | 4 | Tag of the dispatched station |

## Verification
The assertions assume two things about the broadcast bus. A station's own tag is broadcast only after that station has been dispatched. The bus never carries tag 0 as a valid result. The bench follows both rules by playing the adder itself: it sends a station's tag only after seeing that tag on the dispatch port. Issue requests made while the bank is full are part of the stimulus, and the bench checks that they leave no trace at the ports.

// File: rtl/rs_pkg.sv
// Package: shared constants for the reservation station bank.
// Assumes producer tags are 4 bits and that tag 0 marks a present value.
package rs_pkg;
    localparam int unsigned RS_TAG_W = 4;
    localparam logic [RS_TAG_W-1:0] TAG_PRESENT = '0;

    typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } rs_op_e;
endpackage

// File: rtl/rs_pick.sv
// Module: rs_pick
// Fixed-priority picker: grants the lowest-index request, one-hot.
// Assumes N >= 2. Used both for free-slot allocation and for dispatch.
module rs_pick #(
    parameter int unsigned N     = 3,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top index down so the lowest request is kept last.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
        any = |req;
    end

    // R9: at most one grant, and it goes to a requester.
    a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & req) == grant));

    // R9: no request below the granted one is pending.
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ((|grant) && (((grant - N'(1)) & req) == '0)));
endmodule

// File: rtl/rs_entry.sv
// Module: rs_entry
// One reservation station: holds an operation and two operands, snoops the
// result bus for missing operands, and stays busy from issue until a
// broadcast carries its own tag after dispatch.
// Assumes alloc is only raised while the entry is free.
module rs_entry
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter logic [RS_TAG_W-1:0] MY_TAG = 4'd10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc,
    input  logic                iss_op,
    input  logic [RS_TAG_W-1:0] iss_a_tag,
    input  logic [DATA_W-1:0]   iss_a_val,
    input  logic [RS_TAG_W-1:0] iss_b_tag,
    input  logic [DATA_W-1:0]   iss_b_val,
    input  logic                res_valid,
    input  logic [RS_TAG_W-1:0] res_tag,
    input  logic [DATA_W-1:0]   res_data,
    input  logic                grant,
    output logic                busy,
    output logic                ready,
    output logic                op,
    output logic [DATA_W-1:0]   a_val,
    output logic [DATA_W-1:0]   b_val
);
    logic [RS_TAG_W-1:0] a_tag, b_tag;
    logic                sent;
    logic                own_result;
    rs_op_e              op_q;

    // Broadcast of this station's own result after it was sent frees it.
    assign own_result = busy && sent && res_valid && (res_tag == MY_TAG);
    // Eligible once both operands are present and not yet dispatched.
    assign ready = busy && !sent && (a_tag == TAG_PRESENT) && (b_tag == TAG_PRESENT);
    assign op    = op_q;

    // Occupancy and dispatch bookkeeping for this station.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            op_q <= OP_ADD;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op_q <= rs_op_e'(iss_op);
        end else if (own_result) begin
            busy <= 1'b0;
            sent <= 1'b0;
        end else if (grant) begin
            sent <= 1'b1;
        end
    end

    // Operand A: load at issue (broadcast first), else snoop the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_tag <= TAG_PRESENT;
            a_val <= '0;
        end else if (alloc) begin
            if (iss_a_tag == TAG_PRESENT) begin
                a_tag <= TAG_PRESENT;
                a_val <= iss_a_val;
            end else if (res_valid && res_tag == iss_a_tag) begin
                a_tag <= TAG_PRESENT;
                a_val <= res_data;
            end else begin
                a_tag <= iss_a_tag;
            end
        end else if (busy && a_tag != TAG_PRESENT && res_valid && res_tag == a_tag) begin
            a_tag <= TAG_PRESENT;
            a_val <= res_data;
        end
    end

    // Operand B: same rules as operand A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_tag <= TAG_PRESENT;
            b_val <= '0;
        end else if (alloc) begin
            if (iss_b_tag == TAG_PRESENT) begin
                b_tag <= TAG_PRESENT;
                b_val <= iss_b_val;
            end else if (res_valid && res_tag == iss_b_tag) begin
                b_tag <= TAG_PRESENT;
                b_val <= res_data;
            end else begin
                b_tag <= iss_b_tag;
            end
        end else if (busy && b_tag != TAG_PRESENT && res_valid && res_tag == b_tag) begin
            b_tag <= TAG_PRESENT;
            b_val <= res_data;
        end
    end

    // R5: a matching broadcast leaves operand A present next cycle.
    a_r5_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !alloc && a_tag != TAG_PRESENT && res_valid && res_tag == a_tag)
        |=> (a_tag == TAG_PRESENT && a_val == $past(res_data)));

    // R7: a granted station has both operands present and is occupied.
    a_r7_grant_needs_operands: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (busy && a_tag == TAG_PRESENT && b_tag == TAG_PRESENT));

    // R10: a station is dispatched once only.
    a_r10_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !ready);

    // R10: occupancy holds until this station's own tag is broadcast.
    a_r10_hold_until_result: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(res_valid && res_tag == MY_TAG)) |=> busy);
endmodule

// File: rtl/rs_bank.sv
// Module: rs_bank
// Bank of reservation stations in front of one adder. Allocates the lowest
// free station on issue, snoops the result bus in every station, and
// dispatches the lowest ready station to the adder each cycle.
// Assumes the adder accepts one operation per cycle and that a station's
// tag is only broadcast after that station was dispatched.
module rs_bank
    import rs_pkg::*;
#(
    parameter int unsigned N_ENT    = 3,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_BASE = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_valid,
    input  logic                iss_op,
    input  logic [RS_TAG_W-1:0] iss_a_tag,
    input  logic [DATA_W-1:0]   iss_a_val,
    input  logic [RS_TAG_W-1:0] iss_b_tag,
    input  logic [DATA_W-1:0]   iss_b_val,
    output logic                iss_ready,
    output logic [RS_TAG_W-1:0] iss_tag,
    input  logic                res_valid,
    input  logic [RS_TAG_W-1:0] res_tag,
    input  logic [DATA_W-1:0]   res_data,
    output logic                disp_valid,
    output logic                disp_op,
    output logic [DATA_W-1:0]   disp_a,
    output logic [DATA_W-1:0]   disp_b,
    output logic [RS_TAG_W-1:0] disp_tag
);
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [RS_TAG_W-1:0] BASE = RS_TAG_W'(TAG_BASE);

    logic [N_ENT-1:0]  busy, ready, free_grant, disp_grant, alloc;
    logic [IDX_W-1:0]  free_idx, disp_idx;
    logic              free_any;
    logic              ent_op [N_ENT];
    logic [DATA_W-1:0] ent_a  [N_ENT];
    logic [DATA_W-1:0] ent_b  [N_ENT];

    // Free-slot picker: lowest free station takes the next issue.
    rs_pick #(.N(N_ENT)) u_free_pick (
        .clk(clk), .rst_n(rst_n), .req(~busy),
        .grant(free_grant), .idx(free_idx), .any(free_any)
    );

    // Dispatch picker: lowest ready station goes to the adder.
    rs_pick #(.N(N_ENT)) u_disp_pick (
        .clk(clk), .rst_n(rst_n), .req(ready),
        .grant(disp_grant), .idx(disp_idx), .any(disp_valid)
    );

    assign iss_ready = free_any;
    assign iss_tag   = BASE + RS_TAG_W'(free_idx);
    assign alloc     = (iss_valid && free_any) ? free_grant : '0;

    // One station per slot, each with its own fixed tag.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        rs_entry #(
            .DATA_W(DATA_W),
            .MY_TAG(RS_TAG_W'(TAG_BASE + g))
        ) u_ent (
            .clk(clk), .rst_n(rst_n), .alloc(alloc[g]),
            .iss_op(iss_op),
            .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
            .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
            .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
            .grant(disp_grant[g]),
            .busy(busy[g]), .ready(ready[g]),
            .op(ent_op[g]), .a_val(ent_a[g]), .b_val(ent_b[g])
        );
    end

    // Dispatch mux: present the selected station to the adder.
    always_comb begin
        disp_op  = ent_op[disp_idx];
        disp_a   = ent_a[disp_idx];
        disp_b   = ent_b[disp_idx];
        disp_tag = BASE + RS_TAG_W'(disp_idx);
    end

    // R2: an accepted issue occupies exactly one previously free station.
    a_r2_alloc_one_free: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> ($countones(busy & ~$past(busy)) == 1));

    // R3: with the bank full, an issue request is not accepted.
    a_r3_full_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (alloc == '0));

    // R8: a station issued this cycle is not dispatched in the same cycle.
    a_r8_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc & disp_grant) == '0);
endmodule

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0, iss_op = 1'b0;
    logic [3:0]  iss_a_tag = '0, iss_b_tag = '0;
    logic [31:0] iss_a_val = '0, iss_b_val = '0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        res_valid = 1'b0;
    logic [3:0]  res_tag = '0;
    logic [31:0] res_data = '0;
    logic        disp_valid, disp_op;
    logic [31:0] disp_a, disp_b;
    logic [3:0]  disp_tag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_bank dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_issue(input bit op, input logic [3:0] at, input logic [31:0] av,
                             input logic [3:0] bt, input logic [31:0] bv);
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = at; iss_a_val = av; iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic clr_issue();
        iss_valid = 1'b0; iss_a_tag = '0; iss_b_tag = '0;
    endtask

    task automatic set_res(input logic [3:0] t, input logic [31:0] d);
        res_valid = 1'b1; res_tag = t; res_data = d;
    endtask

    task automatic clr_res();
        res_valid = 1'b0; res_tag = '0; res_data = '0;
    endtask

    // Broadcast a result for one cycle.
    task automatic broadcast(input logic [3:0] t, input logic [31:0] d);
        set_res(t, d); tick(); clr_res();
    endtask

    task automatic t_reset();
        check(iss_ready == 1'b1, "R1 iss_ready", iss_ready, 1);
        check(iss_tag == 4'd10, "R1 iss_tag", iss_tag, 10);
        check(disp_valid == 1'b0, "R1 disp_valid", disp_valid, 0);
    endtask

    task automatic t_ready_values();
        set_issue(1'b1, 4'd0, 32'd5, 4'd0, 32'd7);
        check(disp_valid == 1'b0, "R8 no dispatch in issue cycle", disp_valid, 0);
        tick(); clr_issue();
        check(disp_valid == 1'b1, "R8 dispatch next cycle", disp_valid, 1);
        check(disp_tag == 4'd10, "R2 first station tag", disp_tag, 10);
        check(disp_a == 32'd5 && disp_b == 32'd7, "R4 operand values", disp_a, 5);
        check(disp_op == 1'b1, "R11 op carried", disp_op, 1);
        check(iss_tag == 4'd11, "R2 next free station", iss_tag, 11);
        tick();
        check(disp_valid == 1'b0, "R10 single dispatch", disp_valid, 0);
        check(iss_tag == 4'd11, "R10 held until result", iss_tag, 11);
        broadcast(4'd10, 32'd12);
        check(iss_tag == 4'd10 && iss_ready, "R10 freed by own tag", iss_tag, 10);
    endtask

    task automatic t_snoop();
        set_issue(1'b0, 4'd4, 32'hDEAD, 4'd0, 32'd3);
        tick(); clr_issue();
        check(disp_valid == 1'b0, "R7 waits for operand", disp_valid, 0);
        broadcast(4'd5, 32'd77);
        check(disp_valid == 1'b0, "R5 other tag ignored", disp_valid, 0);
        broadcast(4'd4, 32'd20);
        check(disp_valid == 1'b1, "R5 dispatch after capture", disp_valid, 1);
        check(disp_a == 32'd20 && disp_b == 32'd3, "R5 captured data", disp_a, 20);
        check(disp_op == 1'b0, "R11 add op", disp_op, 0);
        tick();
        broadcast(4'd10, 32'd23);
        check(iss_tag == 4'd10, "R10 freed", iss_tag, 10);
    endtask

    task automatic t_same_cycle();
        set_issue(1'b0, 4'd0, 32'd8, 4'd6, 32'hBAD);
        set_res(4'd6, 32'd99);
        tick(); clr_issue(); clr_res();
        check(disp_valid == 1'b1, "R6 ready right after issue", disp_valid, 1);
        check(disp_b == 32'd99, "R6 broadcast taken at issue", disp_b, 99);
        tick();
        broadcast(4'd10, 32'd107);
    endtask

    task automatic t_full_and_priority();
        for (int k = 0; k < 3; k++) begin
            set_issue(1'b0, 4'd7, 32'd0, 4'd0, 32'(100 + k));
            check(iss_tag == 4'(10 + k), "R2 lowest free", iss_tag, 10 + k);
            tick();
        end
        clr_issue();
        check(iss_ready == 1'b0, "R3 full", iss_ready, 0);
        set_issue(1'b1, 4'd0, 32'd1, 4'd0, 32'd2);
        tick(); clr_issue();
        tick();
        check(disp_valid == 1'b0, "R3 ignored issue not dispatched", disp_valid, 0);
        check(iss_ready == 1'b0, "R3 still full", iss_ready, 0);
        broadcast(4'd7, 32'd50);
        for (int k = 0; k < 3; k++) begin
            check(disp_valid && disp_tag == 4'(10 + k), "R9 lowest first", disp_tag, 10 + k);
            check(disp_a == 32'd50 && disp_b == 32'(100 + k), "R11 operands", disp_b, 100 + k);
            tick();
        end
        check(disp_valid == 1'b0, "R3 no extra dispatch", disp_valid, 0);
        broadcast(4'd11, 32'd0);
        check(iss_ready && iss_tag == 4'd11, "R10 middle freed", iss_tag, 11);
        broadcast(4'd10, 32'd0);
        broadcast(4'd12, 32'd0);
        check(iss_tag == 4'd10 && iss_ready, "R10 all freed", iss_tag, 10);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_ready_values();
        t_snoop();
        t_same_cycle();
        t_full_and_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule